// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a single-stage integer arithmetic unit that works on two 64-bit operands, each formed from a pair of 32-bit words. A size code in each issued operation splits the operands into eight byte lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. It adds, subtracts, or does both at once on the same operands, in signed or unsigned form. It can also widen elements to twice their size or narrow them to half their size. There is no mode register. Every operation carries its own opcode, size code and signed flag.

Operations enter on a valid/ready stream and leave on a second valid/ready stream through one output register. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is on the output from the next cycle on. `in_ready` is high when the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds every field stable and new operations wait. A caller holding `in_valid` must keep its operation fields stable until the operation is accepted.

Top module: `simd_alu`

## Requirements
- R1: With size code 2'b00 the operands are eight independent byte lanes. No carry or borrow crosses a byte boundary.
- R2: Size code 2'b01 gives four 16-bit lanes and size code 2'b10 gives two 32-bit lanes. No carry crosses a lane boundary.
- R3: Size code 2'b11 gives one 64-bit lane. The carry runs across the boundary between the two 32-bit words.
- R4: Each lane has its own overflow flag. Lane i (lane 0 in the least significant bits) reports on flag bit i. Flag bits above the lane count are zero. Signed: the flag shows that the true result is outside the two's-complement range. Unsigned: it shows a carry out on add or a borrow on subtract.
- R5: Opcode 3'b000 adds, giving a+b. Opcode 3'b001 subtracts, giving a-b. Results wrap modulo the lane width. For both opcodes `out_res1` and `out_ovf1` are zero.
- R6: Opcode 3'b010 returns the sum on `out_res0`/`out_ovf0` and the difference a-b on `out_res1`/`out_ovf1`, both from the same operands.
- R7: Opcode 3'b011 widens. The source lanes of the given size in `in_a[31:0]` are each extended to twice the width: sign-extended when signed, zero-extended when unsigned. With size 2'b11 `in_a` passes unchanged. All flags are zero.
- R8: Opcode 3'b100 narrows. Each source lane of the given size in `in_a` goes to half its width, saturating to the destination range (signed or unsigned). The results are packed into `out_res0[31:0]` and `out_res0[63:32]` is zero. Flag bit i is set when source lane i saturated. With size 2'b00 `in_a` passes unchanged with no flags.
- R9: Opcodes 3'b101 to 3'b111 produce all-zero results and flags.
- R10: The result of an operation accepted at an edge is valid on the outputs after that same edge.
- R11: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs stay stable.
- R12: After reset `out_valid` is low and all result and flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 3 | Opcode |
| in_size | input | 2 | Lane size code |
| in_signed | input | 1 | Signed interpretation |
| in_a | input | 64 | First operand (two packed words) |
| in_b | input | 64 | Second operand (two packed words) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_res0 | output | 64 | Sum, difference or conversion result |
| out_res1 | output | 64 | Difference of a combined operation, else zero |
| out_ovf0 | output | 8 | Per-lane flags for out_res0 |
| out_ovf1 | output | 8 | Per-lane flags for out_res1 |

## Verification
The embedded properties check the stream rules on every cycle: an accepted operation shows up the next cycle, a stalled output stays stable, and a drained register empties. They also check the structural zeros: the second result is zero outside the combined operation, flags above lane 0 are zero in 64-bit mode, and reserved opcodes give zero results. The lane arithmetic itself can only be shown by the bench's behavioural model over its scenarios. Those scenarios cover carry isolation at each lane size, signed against unsigned overflow, sign against zero extension, and saturation at both range limits.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int WORD_W   = 32;
  localparam int DATA_W   = 2 * WORD_W;
  localparam int NUM_BYTE = DATA_W / 8;

  localparam logic [1:0] SZ_BYTE  = 2'b00;
  localparam logic [1:0] SZ_SHORT = 2'b01;
  localparam logic [1:0] SZ_WORD  = 2'b10;
  localparam logic [1:0] SZ_LONG  = 2'b11;

  typedef enum logic [2:0] {
    OPC_ADD    = 3'b000,
    OPC_SUB    = 3'b001,
    OPC_ADDSUB = 3'b010,
    OPC_WIDEN  = 3'b011,
    OPC_NARROW = 3'b100
  } alu_opc_e;

  typedef struct packed {
    logic [DATA_W-1:0]   res0;
    logic [DATA_W-1:0]   res1;
    logic [NUM_BYTE-1:0] ovf0;
    logic [NUM_BYTE-1:0] ovf1;
  } alu_out_t;
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0] a,
  input  logic [NB*8-1:0] b,
  input  logic [1:0]      size,
  input  logic            sgn,
  input  logic            sub,
  output logic [NB*8-1:0] sum,
  output logic [NB-1:0]   ovf
);
  logic [NB-1:0] raw;

  always_comb begin
    logic       c;
    logic [8:0] t;
    logic [7:0] bo;
    c   = 1'b0;
    sum = '0;
    raw = '0;
    for (int k = 0; k < NB; k++) begin
      if ((k & ((1 << size) - 1)) == 0) c = sub;
      bo = sub ? ~b[k*8 +: 8] : b[k*8 +: 8];
      t  = {1'b0, a[k*8 +: 8]} + {1'b0, bo} + {8'd0, c};
      sum[k*8 +: 8] = t[7:0];
      if (sgn) raw[k] = (a[k*8+7] == bo[7]) && (t[7] != a[k*8+7]);
      else     raw[k] = sub ? ~t[8] : t[8];
      c = t[8];
    end
  end

  always_comb begin
    ovf = '0;
    for (int i = 0; i < NB; i++)
      if (i < (NB >> size)) ovf[i] = raw[((i + 1) << size) - 1];
  end
endmodule

// File: rtl/simd_width_conv.sv
module simd_width_conv
  import simd_alu_pkg::*;
(
  input  logic [DATA_W-1:0]   a,
  input  logic [1:0]          size,
  input  logic                sgn,
  input  logic                narrow,
  output logic [DATA_W-1:0]   res,
  output logic [NUM_BYTE-1:0] flg
);
  logic [DATA_W-1:0]   wide_v [4];
  logic [DATA_W-1:0]   nar_v  [4];
  logic [NUM_BYTE-1:0] nar_f  [4];

  for (genvar s = 0; s < 3; s++) begin : g_wid
    localparam int W = 8 << s;
    localparam int N = WORD_W / W;
    for (genvar j = 0; j < N; j++) begin : g_l
      assign wide_v[s][j*2*W +: 2*W] = {{W{sgn & a[j*W+W-1]}}, a[j*W +: W]};
    end
  end
  assign wide_v[3] = a;

  assign nar_v[0] = a;
  assign nar_f[0] = '0;
  for (genvar s = 1; s < 4; s++) begin : g_nar
    localparam int W = 8 << s;
    localparam int H = W / 2;
    localparam int N = DATA_W / W;
    for (genvar j = 0; j < N; j++) begin : g_l
      logic [W-1:0] src;
      logic         fit;
      logic [H-1:0] satv;
      assign src  = a[j*W +: W];
      assign fit  = sgn ? ((src[W-1:H-1] == '0) || (src[W-1:H-1] == '1))
                        : (src[W-1:H] == '0);
      assign satv = sgn ? (src[W-1] ? {1'b1, {(H-1){1'b0}}} : {1'b0, {(H-1){1'b1}}})
                        : {H{1'b1}};
      assign nar_v[s][j*H +: H] = fit ? src[H-1:0] : satv;
      assign nar_f[s][j]        = ~fit;
    end
    assign nar_v[s][DATA_W-1:WORD_W] = '0;
    assign nar_f[s][NUM_BYTE-1:N]    = '0;
  end

  assign res = narrow ? nar_v[size] : wide_v[size];
  assign flg = narrow ? nar_f[size] : '0;
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          in_op,
  input  logic [1:0]          in_size,
  input  logic                in_signed,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_res0,
  output logic [DATA_W-1:0]   out_res1,
  output logic [NUM_BYTE-1:0] out_ovf0,
  output logic [NUM_BYTE-1:0] out_ovf1
);
  logic [DATA_W-1:0]   lane_sum [2];
  logic [NUM_BYTE-1:0] lane_ovf [2];
  logic [DATA_W-1:0]   conv_res;
  logic [NUM_BYTE-1:0] conv_flg;
  alu_out_t            nxt, held;
  logic                accept;

  for (genvar u = 0; u < 2; u++) begin : g_arith
    simd_lane_adder #(.NB(NUM_BYTE)) u_add (
      .a(in_a), .b(in_b), .size(in_size), .sgn(in_signed),
      .sub(u == 1), .sum(lane_sum[u]), .ovf(lane_ovf[u])
    );
  end

  simd_width_conv u_conv (
    .a(in_a), .size(in_size), .sgn(in_signed),
    .narrow(in_op == OPC_NARROW), .res(conv_res), .flg(conv_flg)
  );

  always_comb begin
    nxt = '0;
    case (in_op)
      OPC_ADD:    begin nxt.res0 = lane_sum[0]; nxt.ovf0 = lane_ovf[0]; end
      OPC_SUB:    begin nxt.res0 = lane_sum[1]; nxt.ovf0 = lane_ovf[1]; end
      OPC_ADDSUB: begin
        nxt.res0 = lane_sum[0]; nxt.ovf0 = lane_ovf[0];
        nxt.res1 = lane_sum[1]; nxt.ovf1 = lane_ovf[1];
      end
      OPC_WIDEN, OPC_NARROW: begin nxt.res0 = conv_res; nxt.ovf0 = conv_flg; end
      default: nxt = '0;
    endcase
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      held      <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_res0 = held.res0;
  assign out_res1 = held.res1;
  assign out_ovf0 = held.ovf0;
  assign out_ovf1 = held.ovf1;

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res0) && $stable(out_res1)
                                && $stable(out_ovf0) && $stable(out_ovf1));

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_single_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op != OPC_ADDSUB |=> out_res1 == '0 && out_ovf1 == '0);

  p_long_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_size == SZ_LONG |=> out_ovf0[NUM_BYTE-1:1] == '0);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[2] && (in_op[1:0] != 2'b00) |=> out_res0 == '0 && out_ovf0 == '0);
endmodule

// File: tb/simd_alu_tb_top.sv
`timescale 1ns/1ps
module simd_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        in_signed = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_res0, out_res1;
  logic [7:0]  out_ovf0, out_ovf1;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_signed(in_signed), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_res0(out_res0), .out_res1(out_res1),
    .out_ovf0(out_ovf0), .out_ovf1(out_ovf1)
  );

  function automatic logic [63:0] mk(int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic signed [66:0] lane_val(logic [63:0] v, int i, int w, bit sg);
    logic [63:0] f;
    logic signed [66:0] x;
    f = (v >> (i * w)) & mk(w);
    x = $signed({3'b000, f});
    if (sg && f[w-1]) x = x - (67'sd1 <<< w);
    return x;
  endfunction

  task automatic arith(input logic [63:0] a, b, input int sz, input bit sg, input bit sb,
                       output logic [63:0] r, output logic [7:0] f);
    int w, n;
    logic signed [66:0] x, y, z, lo, hi;
    w = 8 << sz; n = 64 / w; r = '0; f = '0;
    for (int i = 0; i < n; i++) begin
      x = lane_val(a, i, w, sg); y = lane_val(b, i, w, sg);
      z = sb ? x - y : x + y;
      lo = sg ? -(67'sd1 <<< (w - 1)) : 67'sd0;
      hi = sg ? (67'sd1 <<< (w - 1)) - 1 : (67'sd1 <<< w) - 1;
      f[i] = (z < lo) || (z > hi);
      r = r | ((z[63:0] & mk(w)) << (i * w));
    end
  endtask

  task automatic ref_op(input logic [2:0] op, input int sz, input bit sg, input logic [63:0] a, b,
                        output logic [63:0] r0, r1, output logic [7:0] f0, f1);
    int w, h, n;
    logic signed [66:0] x, lo, hi;
    r0 = '0; r1 = '0; f0 = '0; f1 = '0;
    w = 8 << sz;
    case (op)
      3'd0: arith(a, b, sz, sg, 0, r0, f0);
      3'd1: arith(a, b, sz, sg, 1, r0, f0);
      3'd2: begin arith(a, b, sz, sg, 0, r0, f0); arith(a, b, sz, sg, 1, r1, f1); end
      3'd3: if (sz == 3) r0 = a;
            else for (int i = 0; i < 32 / w; i++) begin
              x = lane_val(a, i, w, sg);
              r0 = r0 | ((x[63:0] & mk(2 * w)) << (i * 2 * w));
            end
      3'd4: if (sz == 0) r0 = a;
            else begin
              h = w / 2; n = 64 / w;
              lo = sg ? -(67'sd1 <<< (h - 1)) : 67'sd0;
              hi = sg ? (67'sd1 <<< (h - 1)) - 1 : (67'sd1 <<< h) - 1;
              for (int i = 0; i < n; i++) begin
                x = lane_val(a, i, w, sg);
                if (x < lo) begin x = lo; f0[i] = 1; end
                if (x > hi) begin x = hi; f0[i] = 1; end
                r0 = r0 | ((x[63:0] & mk(h)) << (i * h));
              end
            end
      default: ;
    endcase
  endtask

  function automatic string tag_of(logic [2:0] op, logic [1:0] sz);
    case (op)
      3'd0: return (sz == 0) ? "R1" : (sz == 3) ? "R3" : "R2";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  // cycle-by-cycle behavioural model of the output register
  logic        m_valid = 0;
  logic [63:0] m_r0 = 0, m_r1 = 0;
  logic [7:0]  m_f0 = 0, m_f1 = 0;
  string       m_tag = "R12";
  bit          m_acc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_r0 = 0; m_r1 = 0; m_f0 = 0; m_f1 = 0; m_acc = 0; m_tag = "R12";
    end else begin
      m_acc = in_valid && (!m_valid || out_ready);
      if (m_acc) begin
        ref_op(in_op, int'(in_size), in_signed, in_a, in_b, m_r0, m_r1, m_f0, m_f1);
        m_tag = tag_of(in_op, in_size);
        m_valid = 1;
      end else if (out_ready) m_valid = 0;
    end
  end

  task automatic chk64(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk64("R11", "in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
    chk64("R10", "out_valid", 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      chk64(m_tag, "res0", out_res0, m_r0);
      chk64("R6", "res1", out_res1, m_r1);
      chk64("R4", "ovf0", 64'(out_ovf0), 64'(m_f0));
      chk64("R6", "ovf1", 64'(out_ovf1), 64'(m_f1));
    end
  endtask

  logic [2:0]  q_op [$];
  logic [1:0]  q_sz [$];
  bit          q_sg [$];
  logic [63:0] q_a [$], q_b [$];

  task automatic push(logic [2:0] op, logic [1:0] sz, bit sg, logic [63:0] a, b);
    q_op.push_back(op); q_sz.push_back(sz); q_sg.push_back(sg); q_a.push_back(a); q_b.push_back(b);
  endtask

  initial begin
    // R1: 0xFF+0x01 per byte must not carry into neighbours
    push(3'd0, 2'b00, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    // R4: signed byte 0x7F+1 overflows, unsigned does not
    push(3'd0, 2'b00, 1, 64'h007F_007F_007F_007F, 64'h0001_0001_0001_0001);
    push(3'd0, 2'b00, 0, 64'h007F_007F_007F_007F, 64'h0001_0001_0001_0001);
    // R2: short and word lanes
    push(3'd0, 2'b01, 0, 64'h0000_FFFF_8000_FFFF, 64'h0000_0001_8000_0001);
    push(3'd0, 2'b10, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001);
    // R3: carry crosses the word boundary
    push(3'd0, 2'b11, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    push(3'd0, 2'b11, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
    // R5: unsigned borrow per lane
    push(3'd1, 2'b00, 0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
    push(3'd1, 2'b01, 1, 64'h8000_8000_0000_7FFF, 64'h0001_8000_0001_FFFF);
    // R6: combined
    push(3'd2, 2'b00, 1, 64'h7F80_0102_0304_0506, 64'h0101_0201_0403_0605);
    push(3'd2, 2'b10, 0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0001);
    // R7: widening
    push(3'd3, 2'b00, 1, 64'h1111_1111_807F_FF01, 64'h0);
    push(3'd3, 2'b00, 0, 64'h1111_1111_807F_FF01, 64'h0);
    push(3'd3, 2'b01, 1, 64'h0, 64'h0);
    push(3'd3, 2'b10, 1, 64'h0000_0000_8000_0000, 64'h0);
    push(3'd3, 2'b11, 1, 64'hDEAD_BEEF_0123_4567, 64'h0);
    // R8: narrowing with saturation at both ends
    push(3'd4, 2'b01, 1, 64'h1234_FF80_FF7F_007F, 64'h0);
    push(3'd4, 2'b01, 0, 64'h1234_00FF_0100_0080, 64'h0);
    push(3'd4, 2'b10, 1, 64'h8000_0000_0000_7FFF, 64'h0);
    push(3'd4, 2'b11, 1, 64'hFFFF_FFFF_8000_0000, 64'h0);
    push(3'd4, 2'b00, 1, 64'hCAFE_F00D_1234_5678, 64'h0);
    // R9: reserved opcodes
    push(3'd5, 2'b00, 0, 64'hFFFF, 64'hFFFF);
    push(3'd7, 2'b11, 1, 64'h1, 64'h1);
    for (int i = 0; i < 3000; i++)
      push(3'($urandom_range(0, 5)), 2'($urandom), 1'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom});
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk64("R12", "out_valid in reset", 64'(out_valid), 64'd0);
    chk64("R12", "res0 in reset", out_res0, 64'd0);
    chk64("R12", "res1 in reset", out_res1, 64'd0);
    chk64("R12", "flags in reset", {48'd0, out_ovf1, out_ovf0}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    while (q_op.size() > 0 || m_valid) begin
      compare_all();
      if (in_valid && m_acc) begin
        void'(q_op.pop_front()); void'(q_sz.pop_front()); void'(q_sg.pop_front());
        void'(q_a.pop_front()); void'(q_b.pop_front());
      end
      if (q_op.size() > 0) begin
        in_valid = 1; in_op = q_op[0]; in_size = q_sz[0]; in_signed = q_sg[0];
        in_a = q_a[0]; in_b = q_b[0];
      end else in_valid = 0;
      // R11: stalls after the directed set
      out_ready = (q_op.size() > 2990) ? 1'b1 : ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    compare_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule